// File: doc/BRIEF.md
# E1 Loopback Path Selector

This block steers 32-slot E1 frame data between a system-side TDM port and a line-side framer port. It is used to isolate faults on a link. Both sides move one 8-bit time slot per clock. The system side carries its own slot count and a frame strobe. The line receive side carries a separate slot count, and the line transmit side is aligned to that count. The two sides do not need to agree on slot phase, because a one-frame elastic buffer in each direction re-aligns slot numbers.

Software sets a whole-stream loopback control word and a 32-entry table of per-slot loopback bits. Four whole-stream loops are available:
- a digital loop, taken after the transmit buffer;
- a system-side loop, taken at the port itself;
- a remote loop, which sends line data straight back to the line;
- a payload loop, which echoes line payload but regenerates slot 0 locally, alternating alignment and non-alignment words with local data-link bits.

A fifth control bit only drives an enable for an external analog loop switch. Each side switches its settings only at its own frame boundary, so no slot is ever split between two configurations.

Top module: `e1_loop_selector`

## Requirements
- R1: After reset, `sys_out_data`, `line_tx_data` and `analog_loop_en` are 0. Both elastic buffers hold 0. The payload frame parity starts even.
- R2: With no loop in force on a side, the outputs come from the elastic buffers. In the cycle after the system port shows slot s, `sys_out_data` carries the line data last received for slot s. In the cycle after the line port shows slot s, `line_tx_data` carries the system data last received for slot s. A buffer read in the same cycle as a write to the same slot returns the older value.
- R3: Under digital loop, in the cycle after system slot s, `sys_out_data` equals the system input of slot s from the previous frame. The line transmit side keeps its normal path.
- R4: Under remote loop, `line_tx_data` equals the previous cycle's `line_rx_data`. The system side keeps its normal path.
- R5: Under system-side loop, `sys_out_data` equals the previous cycle's `sys_in_data`.
- R6: Under payload loop, `line_tx_data` echoes the previous cycle's `line_rx_data` for slots 1 to 31. For line slot 0, the block sends 8'h9B in even frames and {3'b110, `dl_bits`} in odd frames. The parity toggles at every line slot 0.
- R7: In `loop_ctrl`, bit 0 is digital, bit 1 remote, bit 2 system-side, bit 3 payload and bit 4 analog, and 1 enables. When several of bits 0 to 3 are set, digital wins over payload, payload over system-side, and system-side over remote.
- R8: Per-slot control word bit 4 set for slot s, with no whole-stream loop in force on the system side, makes `sys_out_data` for slot s equal the previous cycle's `sys_in_data`.
- R9: Per-slot control word bit 5 set for slot s, with no whole-stream loop in force on the line side, makes `line_tx_data` for slot s equal the previous cycle's `line_rx_data`. The other bits of the word have no effect.
- R10: Any whole-stream loop (bits 0 to 3) on a side overrides that side's per-slot loop bits. The analog bit alone does not.
- R11: The system side adopts `loop_ctrl` and the per-slot local bits in the cycle where `sys_frame` is high. The line side adopts them in the cycle where `line_rx_slot` is 0. Both are used for that slot. A per-slot write is not seen before the following boundary.
- R12: `analog_loop_en` takes `loop_ctrl` bit 4 at each line boundary, whatever the other bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_in_data | input | 8 | System-side slot data in |
| sys_in_slot | input | 5 | System-side slot number |
| sys_frame | input | 1 | System frame strobe, high with slot 0 |
| sys_out_data | output | 8 | System-side slot data out, one cycle behind `sys_in_slot` |
| line_rx_data | input | 8 | Line receive slot data |
| line_rx_slot | input | 5 | Line receive slot number |
| line_tx_data | output | 8 | Line transmit slot data, one cycle behind `line_rx_slot` |
| loop_ctrl | input | 5 | Whole-stream loopback enables |
| ts_wr_en | input | 1 | Per-slot control table write strobe |
| ts_wr_addr | input | 5 | Slot whose control word is written |
| ts_wr_data | input | 8 | Per-slot control word (bit 5 remote, bit 4 local) |
| dl_bits | input | 5 | Local data-link bits for regenerated slot 0 |
| analog_loop_en | output | 1 | Enable for the external analog loop switch |

## Verification
The collision that matters most is a control change landing on a frame boundary in the same cycle that the elastic buffer reads and writes the same slot. The bench provokes it by running the line slot offset at 0, where both sides cross slot 0 together. It holds each of the 32 control words for a span that is not a whole number of frames, so changes fall both mid-frame and on boundaries. Every cycle is judged against a bench model of both buffers, both latched control sets and the payload parity. A cycle that sits on a boundary is tagged with the boundary requirement as well as the path requirement.

// File: rtl/e1lb_pkg.sv
package e1lb_pkg;

   // whole-stream control word bit positions (software visible)
   localparam int CTL_W   = 5;
   localparam int CTL_DIG = 0;
   localparam int CTL_REM = 1;
   localparam int CTL_SYS = 2;
   localparam int CTL_PAY = 3;
   localparam int CTL_ANA = 4;

   // per-slot control word bit positions
   localparam int TS_LOC_BIT = 4;
   localparam int TS_REM_BIT = 5;

   typedef enum logic [2:0] {
      LB_NONE = 3'd0,
      LB_DIG  = 3'd1,
      LB_PAY  = 3'd2,
      LB_SYS  = 3'd3,
      LB_REM  = 3'd4
   } lb_mode_e;

   // fixed priority: digital > payload > system-side > remote
   function automatic lb_mode_e lb_decode(input logic [CTL_W-1:0] c);
      if (c[CTL_DIG])      return LB_DIG;
      else if (c[CTL_PAY]) return LB_PAY;
      else if (c[CTL_SYS]) return LB_SYS;
      else if (c[CTL_REM]) return LB_REM;
      else                 return LB_NONE;
   endfunction

endpackage

// File: rtl/e1lb_frame_latch.sv
module e1lb_frame_latch #(
   parameter int CW    = 5,
   parameter int SLOTS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boundary,
   input  logic [CW-1:0]    ctrl_in,
   input  logic [SLOTS-1:0] mask_in,
   output logic [CW-1:0]    ctrl_eff,
   output logic [SLOTS-1:0] mask_eff
);

   logic [CW-1:0]    ctrl_q;
   logic [SLOTS-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
      end else if (boundary) begin
         ctrl_q <= ctrl_in;
         mask_q <= mask_in;
      end
   end

   // the boundary slot already uses the new setting
   assign ctrl_eff = boundary ? ctrl_in : ctrl_q;
   assign mask_eff = boundary ? mask_in : mask_q;

endmodule

// File: rtl/e1lb_slot_buf.sv
module e1lb_slot_buf #(
   parameter int SLOTS = 32,
   parameter int DW    = 8,
   parameter int NRD   = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(SLOTS)-1:0] waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [NRD-1:0][$clog2(SLOTS)-1:0] raddr,
   output logic [NRD-1:0][DW-1:0]   rdata
);

   localparam int AW = $clog2(SLOTS);

   logic [DW-1:0] mem [SLOTS];

   generate
      if (NRD < 1) begin : g_bad_nrd
         $error("e1lb_slot_buf needs at least one read port");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
      end else begin
         mem[waddr] <= wdata;
      end
   end

   // read-before-write: a same-slot read sees last frame's byte
   for (genvar p = 0; p < NRD; p++) begin : g_rd
      logic [AW-1:0] ra;
      assign ra       = raddr[p];
      assign rdata[p] = mem[ra];
   end

endmodule

// File: rtl/e1lb_slot0_gen.sv
module e1lb_slot0_gen #(
   parameter int          DW        = 8,
   parameter int          DL_W      = 5,
   parameter logic [DW-1:0] FAS_WORD = 8'h9B,
   parameter logic [DW-DL_W-1:0] NFAS_HEAD = 3'b110
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_start,
   input  logic [DL_W-1:0] dl_bits,
   output logic [DW-1:0]   word
);

   generate
      if (DL_W >= DW) begin : g_bad_dl
         $error("data-link field must be narrower than a slot");
      end
   endgenerate

   logic odd_q;

   always_ff @(posedge clk) begin
      if (!rst_n)           odd_q <= 1'b0;
      else if (frame_start) odd_q <= ~odd_q;
   end

   assign word = odd_q ? {NFAS_HEAD, dl_bits} : FAS_WORD;

endmodule

// File: rtl/e1_loop_selector.sv
module e1_loop_selector
   import e1lb_pkg::*;
#(
   parameter int SLOTS = 32,
   parameter int DW    = 8,
   parameter int DL_W  = 5,
   parameter int TSW_W = 8,
   parameter logic [DW-1:0] FAS_WORD = 8'h9B,
   parameter logic [DW-DL_W-1:0] NFAS_HEAD = 3'b110,
   localparam int SW = $clog2(SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DW-1:0]    sys_in_data,
   input  logic [SW-1:0]    sys_in_slot,
   input  logic             sys_frame,
   output logic [DW-1:0]    sys_out_data,
   input  logic [DW-1:0]    line_rx_data,
   input  logic [SW-1:0]    line_rx_slot,
   output logic [DW-1:0]    line_tx_data,
   input  logic [CTL_W-1:0] loop_ctrl,
   input  logic             ts_wr_en,
   input  logic [SW-1:0]    ts_wr_addr,
   input  logic [TSW_W-1:0] ts_wr_data,
   input  logic [DL_W-1:0]  dl_bits,
   output logic             analog_loop_en
);

   generate
      if ((1 << SW) != SLOTS) begin : g_bad_slots
         $error("SLOTS must be a power of two");
      end
      if (TSW_W <= TS_REM_BIT) begin : g_bad_tsw
         $error("per-slot control word too narrow");
      end
   endgenerate

   // ---------------- per-slot control table (staged) ----------------
   logic [SLOTS-1:0] stage_loc, stage_rem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_loc <= '0;
         stage_rem <= '0;
      end else if (ts_wr_en) begin
         stage_loc[ts_wr_addr] <= ts_wr_data[TS_LOC_BIT];
         stage_rem[ts_wr_addr] <= ts_wr_data[TS_REM_BIT];
      end
   end

   // ---------------- frame-boundary latches, one per side ----------------
   logic             line_frame;
   logic [CTL_W-1:0] sys_ctrl_eff, line_ctrl_eff;
   logic [SLOTS-1:0] sys_loc_eff, line_rem_eff;

   assign line_frame = (line_rx_slot == '0);

   e1lb_frame_latch #(.CW(CTL_W), .SLOTS(SLOTS)) u_sys_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (sys_frame),
      .ctrl_in  (loop_ctrl),
      .mask_in  (stage_loc),
      .ctrl_eff (sys_ctrl_eff),
      .mask_eff (sys_loc_eff)
   );

   e1lb_frame_latch #(.CW(CTL_W), .SLOTS(SLOTS)) u_line_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .boundary (line_frame),
      .ctrl_in  (loop_ctrl),
      .mask_in  (stage_rem),
      .ctrl_eff (line_ctrl_eff),
      .mask_eff (line_rem_eff)
   );

   lb_mode_e sys_mode, line_mode;
   assign sys_mode  = lb_decode(sys_ctrl_eff);
   assign line_mode = lb_decode(line_ctrl_eff);

   // ---------------- elastic buffers ----------------
   logic [1:0][DW-1:0] tx_rd;
   logic [0:0][DW-1:0] rx_rd;

   // transmit buffer: port 0 read on system timing, port 1 on line timing
   e1lb_slot_buf #(.SLOTS(SLOTS), .DW(DW), .NRD(2)) u_txbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .waddr (sys_in_slot),
      .wdata (sys_in_data),
      .raddr ({line_rx_slot, sys_in_slot}),
      .rdata (tx_rd)
   );

   e1lb_slot_buf #(.SLOTS(SLOTS), .DW(DW), .NRD(1)) u_rxbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .waddr (line_rx_slot),
      .wdata (line_rx_data),
      .raddr (sys_in_slot),
      .rdata (rx_rd)
   );

   // ---------------- slot 0 regeneration ----------------
   logic [DW-1:0] slot0_word;

   e1lb_slot0_gen #(
      .DW(DW), .DL_W(DL_W), .FAS_WORD(FAS_WORD), .NFAS_HEAD(NFAS_HEAD)
   ) u_slot0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (line_frame),
      .dl_bits     (dl_bits),
      .word        (slot0_word)
   );

   // ---------------- output selection ----------------
   logic [DW-1:0] sys_nxt, line_nxt;

   always_comb begin
      case (sys_mode)
         LB_DIG:  sys_nxt = tx_rd[0];
         LB_SYS:  sys_nxt = sys_in_data;
         LB_NONE: sys_nxt = sys_loc_eff[sys_in_slot] ? sys_in_data : rx_rd[0];
         default: sys_nxt = rx_rd[0];
      endcase
   end

   always_comb begin
      case (line_mode)
         LB_REM:  line_nxt = line_rx_data;
         LB_PAY:  line_nxt = line_frame ? slot0_word : line_rx_data;
         LB_NONE: line_nxt = line_rem_eff[line_rx_slot] ? line_rx_data : tx_rd[1];
         default: line_nxt = tx_rd[1];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sys_out_data   <= '0;
         line_tx_data   <= '0;
         analog_loop_en <= 1'b0;
      end else begin
         sys_out_data   <= sys_nxt;
         line_tx_data   <= line_nxt;
         analog_loop_en <= line_ctrl_eff[CTL_ANA];
      end
   end

endmodule

// File: rtl/e1lb_checker.sv
module e1lb_checker
   import e1lb_pkg::*;
#(
   parameter int SLOTS = 32,
   parameter int DW    = 8,
   parameter int DL_W  = 5,
   parameter logic [DW-1:0] FAS_WORD = 8'h9B,
   parameter logic [DW-DL_W-1:0] NFAS_HEAD = 3'b110,
   localparam int SW = $clog2(SLOTS)
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] sys_in_data,
   input logic          sys_frame,
   input logic [DW-1:0] sys_out_data,
   input logic [DW-1:0] line_rx_data,
   input logic [SW-1:0] line_rx_slot,
   input logic [DW-1:0] line_tx_data,
   input logic          analog_loop_en,
   input lb_mode_e      sys_mode,
   input lb_mode_e      line_mode
);

   assert_sys_loop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_mode == LB_SYS) |=> (sys_out_data == $past(sys_in_data)));

   assert_remote_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_mode == LB_REM) |=> (line_tx_data == $past(line_rx_data)));

   assert_payload_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_mode == LB_PAY && line_rx_slot == '0) |=>
         (line_tx_data == FAS_WORD || line_tx_data[DW-1:DL_W] == NFAS_HEAD));

   assert_payload_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_mode == LB_PAY && line_rx_slot != '0) |=>
         (line_tx_data == $past(line_rx_data)));

   assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_frame ##1 !sys_frame) |-> $stable(sys_mode));

   assert_analog_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (line_rx_slot != '0) |=> $stable(analog_loop_en));

endmodule

bind e1_loop_selector e1lb_checker #(
   .SLOTS(SLOTS), .DW(DW), .DL_W(DL_W), .FAS_WORD(FAS_WORD), .NFAS_HEAD(NFAS_HEAD)
) u_e1lb_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .sys_in_data    (sys_in_data),
   .sys_frame      (sys_frame),
   .sys_out_data   (sys_out_data),
   .line_rx_data   (line_rx_data),
   .line_rx_slot   (line_rx_slot),
   .line_tx_data   (line_tx_data),
   .analog_loop_en (analog_loop_en),
   .sys_mode       (sys_mode),
   .line_mode      (line_mode)
);

// File: tb/e1_loop_selector_test.sv
`timescale 1ns/1ps
module e1_loop_selector_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] sys_in_data, line_rx_data, sys_out_data, line_tx_data, ts_wr_data;
   logic [4:0] sys_in_slot, line_rx_slot, loop_ctrl, ts_wr_addr, dl_bits;
   logic       sys_frame, ts_wr_en, analog_loop_en;

   always #2.5 clk = ~clk;

   e1_loop_selector uut (
      .clk(clk), .rst_n(rst_n),
      .sys_in_data(sys_in_data), .sys_in_slot(sys_in_slot), .sys_frame(sys_frame),
      .sys_out_data(sys_out_data),
      .line_rx_data(line_rx_data), .line_rx_slot(line_rx_slot), .line_tx_data(line_tx_data),
      .loop_ctrl(loop_ctrl), .ts_wr_en(ts_wr_en), .ts_wr_addr(ts_wr_addr),
      .ts_wr_data(ts_wr_data), .dl_bits(dl_bits), .analog_loop_en(analog_loop_en)
   );

   int vectors = 0, miscompares = 0;
   bit done = 1'b0;
   int cyc = 0, off = 0;

   // reference state
   logic [7:0]  m_tx [32];
   logic [7:0]  m_rx [32];
   logic [4:0]  m_sctl, m_lctl;
   logic [31:0] m_sloc, m_lrem, st_loc, st_rem;
   bit          m_odd;

   // 0 none, 1 digital, 2 payload, 3 system, 4 remote (R7 priority)
   function automatic int mode_of(input logic [4:0] c);
      if (c[0]) return 1;
      if (c[3]) return 2;
      if (c[2]) return 3;
      if (c[1]) return 4;
      return 0;
   endfunction

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s cyc=%0d actual=%02h expected=%02h", req, cyc, act, exp);
      end
   endtask

   task automatic step(input logic [4:0] ctl, input bit wr, input logic [4:0] wa,
                       input logic [7:0] wd);
      int s, l, sm, lm;
      logic [7:0] sin, lin, es, el;
      logic [4:0] sc, lc, dl;
      bit sfr, lfr, sl, lr, ea;
      string rs, rl;
      @(negedge clk);
      s   = cyc % 32;
      l   = (cyc + off) % 32;
      sin = 8'((cyc * 37 + 5) ^ (cyc >> 5));
      lin = 8'((cyc * 91) ^ (cyc >> 3) ^ 8'h5A);
      dl  = 5'((cyc / 32) * 3 + off);
      sys_in_data = sin; sys_in_slot = 5'(s); sys_frame = (s == 0);
      line_rx_data = lin; line_rx_slot = 5'(l);
      loop_ctrl = ctl; ts_wr_en = wr; ts_wr_addr = wa; ts_wr_data = wd; dl_bits = dl;
      sfr = (s == 0); lfr = (l == 0);
      sc = sfr ? ctl : m_sctl;      lc = lfr ? ctl : m_lctl;
      sl = sfr ? st_loc[s] : m_sloc[s];
      lr = lfr ? st_rem[l] : m_lrem[l];
      sm = mode_of(sc); lm = mode_of(lc);
      // system output
      if (sm == 1)                begin es = m_tx[s]; rs = "R3"; end
      else if (sm == 3)           begin es = sin;     rs = "R5"; end
      else if (sm == 0 && sl)     begin es = sin;     rs = "R8"; end
      else                        begin es = m_rx[s]; rs = "R2"; end
      // line output
      if (lm == 4)                begin el = lin; rl = "R4"; end
      else if (lm == 2)           begin el = (l == 0) ? (m_odd ? {3'b110, dl} : 8'h9B) : lin; rl = "R6"; end
      else if (lm == 0 && lr)     begin el = lin; rl = "R9"; end
      else                        begin el = m_tx[l]; rl = "R2"; end
      ea = lc[4];
      if ($countones(sc[3:0]) > 1) rs = {rs, " R7"};
      if ($countones(lc[3:0]) > 1) rl = {rl, " R7"};
      if (sm != 0 && sl) rs = {rs, " R10"};
      if (lm != 0 && lr) rl = {rl, " R10"};
      if (sfr) rs = {rs, " R11"};
      if (lfr) rl = {rl, " R11"};
      // model update
      if (sfr) begin m_sctl = ctl; m_sloc = st_loc; end
      if (lfr) begin m_lctl = ctl; m_lrem = st_rem; m_odd = !m_odd; end
      m_tx[s] = sin;
      m_rx[l] = lin;
      if (wr) begin st_loc[wa] = wd[4]; st_rem[wa] = wd[5]; end
      @(posedge clk);
      #1;
      check8(rs, sys_out_data, es);
      check8(rl, line_tx_data, el);
      check8("R12", {7'd0, analog_loop_en}, {7'd0, ea});
      cyc++;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) begin m_tx[i] = '0; m_rx[i] = '0; end
      m_sctl = '0; m_lctl = '0; m_sloc = '0; m_lrem = '0; st_loc = '0; st_rem = '0;
      m_odd = 1'b0;
      rst_n = 1'b0;
      sys_in_data = '0; sys_in_slot = '0; sys_frame = 1'b0; line_rx_data = '0;
      line_rx_slot = 5'd3; loop_ctrl = 5'h1F; ts_wr_en = 1'b0; ts_wr_addr = '0;
      ts_wr_data = '0; dl_bits = '0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state seen at the ports
      check8("R1", sys_out_data, 8'h00);
      check8("R1", line_tx_data, 8'h00);
      check8("R1", {7'd0, analog_loop_en}, 8'h00);
      foreach (off_list[k]) begin
         off = off_list[k];
         // per-slot phase: no whole-stream loop, analog bit toggled halfway
         for (int c = 0; c < 256; c++)
            step((c < 128) ? 5'h00 : 5'h10, (c % 3) == 0, 5'((cyc * 7) % 32),
                 8'((cyc * 13) ^ ((cyc / 3) << 4)));
         // sweep all control words, held for a non-frame-multiple span
         for (int v = 0; v < 32; v++)
            for (int c = 0; c < 103; c++)
               step(5'(v), (c % 11) == 0, 5'((cyc * 5) % 32), 8'(cyc ^ (v << 4)));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   int off_list [3] = '{0, 5, 31};

endmodule